// File: doc/BRIEF.md
# Conditional Trap Evaluator

This block decides whether a trap-word instruction should raise an exception. On an issue strobe it takes a first operand from a register and a second operand that is either a register value or a 16-bit immediate. An immediate is sign-extended to the full data width. The block compares the two operands as signed numbers and as unsigned numbers, which gives five relations: signed less, signed greater, equal, unsigned less and unsigned greater.

A 5-bit condition mask chooses which of these relations can cause a trap. If any relation that is both enabled and true holds, the block raises a one-cycle trap request on the clock edge after the issue strobe. With the request it gives a cause code that marks a program exception with a trap sub-cause. The surrounding pipeline handles vectoring to the handler and flushing younger work. The block only produces the decision and the cause.

Top module: `trap_eval`

## Requirements
- R1: When `use_imm_i` is 1 the second operand is `imm_i` sign-extended to 32 bits and `reg_b_i` has no effect. When `use_imm_i` is 0 the second operand is `reg_b_i`.
- R2: Mask bit 4 (value 0x10) enables a trap when the first operand is less than the second, compared as two's-complement signed values.
- R3: Mask bit 3 (value 0x08) enables a trap when the first operand is greater than the second, compared as signed values.
- R4: Mask bit 2 (value 0x04) enables a trap when the two operands are equal.
- R5: Mask bit 1 (value 0x02) enables a trap when the first operand is less than the second, compared as unsigned values.
- R6: Mask bit 0 (value 0x01) enables a trap when the first operand is greater than the second, compared as unsigned values.
- R7: A trap is raised when the OR of all enabled true relations is 1. A mask of 0x1F therefore always traps, and a mask of 0x00 never traps.
- R8: `cause_o` is 8'h72 while `trap_o` is 1. The upper nibble 7 is the program-exception class and the lower nibble 2 is the trap sub-cause. `cause_o` is 8'h00 otherwise.
- R9: `trap_o` is registered. It is high for exactly the one cycle after a clock edge that sampled `issue_i` high with a true enabled condition. With no issue strobe it stays low.
- R10: A synchronous active-high `rst` clears `trap_o` and `cause_o`, and it takes priority over an issue strobe sampled at the same edge.
- R11: The sign-extended immediate is used in the unsigned comparisons too. For example, immediate 0x8000 compares as the unsigned value 0xFFFF8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Evaluate the operands on this cycle |
| src_a_i | input | 32 | First operand |
| reg_b_i | input | 32 | Second operand from a register |
| imm_i | input | 16 | Immediate second operand before sign extension |
| use_imm_i | input | 1 | Selects the immediate as second operand |
| cond_mask_i | input | 5 | Enabled relations: bit4 slt, bit3 sgt, bit2 eq, bit1 ult, bit0 ugt |
| trap_o | output | 1 | One-cycle trap request |
| cause_o | output | 8 | Exception cause code when trapping |

## Verification
Each relation is tried with single-bit masks on operand pairs where the signed and unsigned orderings disagree, such as -1 against 1 and 0x80000000 against 0x7FFFFFFF. These pairs show whether a relation is wired to the wrong domain or the wrong mask bit. The immediate cases use 0xFFFF, 0x8000 and a small positive value together with a deliberately different register value. They catch a zero-extended immediate, an immediate used only on the signed side, and a mux that leaks the register value. Multi-bit masks, the all-ones mask and the zero mask check the OR. Issue-free cycles and a reset that coincides with an issue check the pulse timing.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int MASK_W = 5;

    // Field order matches the mask bit positions (first field is bit 4).
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;

    typedef struct packed {
        logic [3:0] cls;
        logic [3:0] sub;
    } cause_t;

    localparam logic [3:0] CLS_PROGRAM = 4'h7;
    localparam logic [3:0] SUB_TRAP    = 4'h2;

    localparam cause_t CAUSE_NONE = '{cls: 4'h0, sub: 4'h0};
    localparam cause_t CAUSE_TRAP = '{cls: CLS_PROGRAM, sub: SUB_TRAP};

    function automatic logic any_enabled(input rel_t rel, input logic [MASK_W-1:0] mask);
        return |(rel & mask);
    endfunction

    function automatic cause_t cause_for(input logic fire);
        return fire ? CAUSE_TRAP : CAUSE_NONE;
    endfunction

endpackage

// File: rtl/trap_opsel.sv
module trap_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_noext
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        opnd_b = use_imm ? imm_ext : reg_b;
    end
endmodule

// File: rtl/trap_compare.sv
module trap_compare
    import trap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output rel_t              rel
);
    logic signed [DATA_W-1:0] sa;
    logic signed [DATA_W-1:0] sb;

    always_comb begin
        sa      = $signed(opnd_a);
        sb      = $signed(opnd_b);
        rel.slt = sa < sb;
        rel.sgt = sa > sb;
        rel.eq  = opnd_a == opnd_b;
        rel.ult = opnd_a < opnd_b;
        rel.ugt = opnd_a > opnd_b;
    end
endmodule

// File: rtl/trap_qualify.sv
module trap_qualify
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [MASK_W-1:0] mask,
    input  rel_t              rel,
    output logic              trap_q,
    output cause_t            cause_q
);
    logic fire;

    always_comb begin
        fire = issue && any_enabled(rel, mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            trap_q  <= fire;
            cause_q <= cause_for(fire);
        end
    end
endmodule

// File: rtl/trap_eval.sv
module trap_eval
    import trap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] reg_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic [MASK_W-1:0] cond_mask_i,
    output logic              trap_o,
    output logic [7:0]        cause_o
);
    logic [DATA_W-1:0] opnd_b;
    rel_t              rel;
    cause_t            cause_q;

    trap_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .reg_b   (reg_b_i),
        .imm     (imm_i),
        .use_imm (use_imm_i),
        .opnd_b  (opnd_b)
    );

    trap_compare #(.DATA_W(DATA_W)) u_cmp (
        .opnd_a (src_a_i),
        .opnd_b (opnd_b),
        .rel    (rel)
    );

    trap_qualify u_qual (
        .clk     (clk),
        .rst     (rst),
        .issue   (issue_i),
        .mask    (cond_mask_i),
        .rel     (rel),
        .trap_q  (trap_o),
        .cause_q (cause_q)
    );

    assign cause_o = cause_q;
endmodule

// File: rtl/trap_eval_chk.sv
module trap_eval_chk
    import trap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              issue_i,
    input logic [MASK_W-1:0] cond_mask_i,
    input logic              trap_o,
    input logic [7:0]        cause_o
);
    // R9: a trap only follows an issue strobe
    assert_trap_needs_issue_R9: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> $past(issue_i));

    // R8: cause while trapping
    assert_cause_on_trap_R8: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> cause_o == 8'h72);

    // R8: cause while idle
    assert_cause_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> cause_o == 8'h00);

    // R7: zero mask never traps
    assert_zero_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_i && cond_mask_i == '0) |=> !trap_o);

    // R7: full mask always traps
    assert_full_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_i && cond_mask_i == '1) |=> trap_o);

    // R10: reset clears the request
    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!trap_o && cause_o == 8'h00));
endmodule

bind trap_eval trap_eval_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue_i),
    .cond_mask_i (cond_mask_i),
    .trap_o      (trap_o),
    .cause_o     (cause_o)
);

// File: tb/test_trap_eval.sv
module test_trap_eval;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_i = 1'b0;
    logic [31:0] src_a_i = '0;
    logic [31:0] reg_b_i = '0;
    logic [15:0] imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic [4:0]  cond_mask_i = '0;
    logic        trap_o;
    logic [7:0]  cause_o;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trap_eval i_trap_eval (
        .clk         (clk),
        .rst         (rst),
        .issue_i     (issue_i),
        .src_a_i     (src_a_i),
        .reg_b_i     (reg_b_i),
        .imm_i       (imm_i),
        .use_imm_i   (use_imm_i),
        .cond_mask_i (cond_mask_i),
        .trap_o      (trap_o),
        .cause_o     (cause_o)
    );

    localparam int NV = 19;
    localparam logic [31:0] VA [NV] = '{
        32'd5, 32'd7, 32'd7, 32'd5, 32'd5, 32'hFFFFFFFF, 32'hFFFFFFFF,
        32'd1, 32'hFFFFFFFF, 32'd1, 32'd1, 32'hFFFFFFFF, 32'd0, 32'd0,
        32'd5, 32'd3, 32'd3, 32'd2, 32'h80000000};
    localparam logic [31:0] VB [NV] = '{
        32'd7, 32'd5, 32'd5, 32'd5, 32'd6, 32'd1, 32'd1,
        32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 32'd0, 32'd0,
        32'd9, 32'd3, 32'd9, 32'd9, 32'h7FFFFFFF};
    localparam logic [15:0] VI [NV] = '{
        16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
        16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h8000, 16'h8000,
        16'h0005, 16'h0, 16'h0, 16'h0, 16'h0};
    localparam logic VU [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [4:0] VM [NV] = '{
        5'h10, 5'h10, 5'h08, 5'h04, 5'h04, 5'h02, 5'h10,
        5'h02, 5'h01, 5'h08, 5'h01, 5'h04, 5'h01, 5'h08,
        5'h04, 5'h1F, 5'h00, 5'h06, 5'h01};
    localparam logic VE [NV] = '{
        1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
        1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam string VR [NV] = '{
        "R2", "R2", "R3", "R4", "R4", "R5", "R2",
        "R5", "R6", "R3", "R6", "R1", "R11", "R11",
        "R1", "R7", "R7", "R7", "R6"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic issue_one(input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] imm, input logic ui,
                             input logic [4:0] m);
        @(negedge clk);
        src_a_i     = a;
        reg_b_i     = b;
        imm_i       = imm;
        use_imm_i   = ui;
        cond_mask_i = m;
        issue_i     = 1'b1;
        @(negedge clk);
        issue_i     = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset trap", {31'd0, trap_o}, 32'd0);
        check("R10 reset cause", {24'd0, cause_o}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue_one(VA[i], VB[i], VI[i], VU[i], VM[i]);
            check(VR[i], {31'd0, trap_o}, {31'd0, VE[i]});
            check("R8 cause", {24'd0, cause_o}, VE[i] ? 32'h72 : 32'h00);
            @(negedge clk);
            check("R9 pulse ends", {31'd0, trap_o}, 32'd0);
        end

        // R9: full mask but no issue strobe -> no trap
        @(negedge clk);
        src_a_i = 32'd4; reg_b_i = 32'd4; use_imm_i = 1'b0; cond_mask_i = 5'h1F;
        @(negedge clk);
        check("R9 no issue", {31'd0, trap_o}, 32'd0);
        @(negedge clk);
        check("R9 no issue cause", {24'd0, cause_o}, 32'd0);

        // R1: immediate selected, register value must not matter
        issue_one(32'hFFFF8000, 32'hFFFF8000, 16'h7000, 1'b1, 5'h04);
        check("R1 reg ignored", {31'd0, trap_o}, 32'd0);

        // R10: reset coinciding with an issue wins
        @(negedge clk);
        src_a_i = 32'd1; reg_b_i = 32'd1; use_imm_i = 1'b0; cond_mask_i = 5'h1F;
        issue_i = 1'b1; rst = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        check("R10 reset over issue", {31'd0, trap_o}, 32'd0);
        rst = 1'b0;

        // R7: back-to-back issues give back-to-back pulses
        @(negedge clk);
        issue_i = 1'b1;
        @(negedge clk);
        check("R7 first of pair", {31'd0, trap_o}, 32'd1);
        cond_mask_i = 5'h00;
        @(negedge clk);
        issue_i = 1'b0;
        check("R7 zero mask second", {31'd0, trap_o}, 32'd0);

        finish_run();
    end
endmodule